// File: doc/BRIEF.md
# Timer Slave-Mode Counter Controller

This block is the counting core of a general-purpose timer. A 4-bit slave-mode code picks how the 16-bit counter advances. It can run on the system clock, step on trigger edges, run only while the trigger is at its active level, be restarted or cleared by a trigger edge, or follow a two-channel quadrature encoder. The trigger and both channel inputs are asynchronous. Each passes through a two-flop synchronizer before any level or edge is used.

The counter counts between 0 and an auto-reload limit. It wraps at either end and marks each wrap, and each trigger-driven reinitialisation, with a one-cycle update pulse. A direction flag shows the sense of the most recent encoder step. A run flag shows the internal start latch that trigger-driven starts set.

Top module: `tmr_slave_counter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `cnt_o` is 0 and `upd_o`, `dir_o` and `run_o` are all 0.
- R2: With code 0, or any code from 9 to 15, the counter rises by exactly one on every clock edge at which `cnt_en_i` is 1. It holds its value while `cnt_en_i` is 0, and channel and trigger activity has no effect on it.
- R3: Counting up from a value equal to `arr_i`, the next step loads 0 and `upd_o` is 1 for that one cycle. Up-steps below the limit leave `upd_o` at 0.
- R4: With code 1, each change of the synchronized channel-1 level moves the counter by one while `cnt_en_i` is 1. The step is up when the new channel-1 level differs from the channel-2 level and down otherwise. Channel-2 changes are ignored.
- R5: With code 2, each change of channel 2 moves the counter by one while `cnt_en_i` is 1. The step is up when the new channel-2 level equals the channel-1 level and down otherwise. Channel-1 changes are ignored.
- R6: With code 3, changes on either channel step the counter, each by the rule of R4 or R5. Taken together, the level pairs (ch1,ch2) = 00, 10, 11, 01, in that cyclic order, count up, and the reverse order counts down.
- R7: Counting down from 0, the next step loads `arr_i` and pulses `upd_o`. `dir_o` is 1 after a down step and 0 after an up step in the encoder codes. `dir_o` is 0 in the cycle after any non-encoder code is applied.
- R8: With code 4, an active trigger edge loads 0 and pulses `upd_o`. Otherwise the counter behaves as in R2. No other code clears the counter from the trigger except code 8.
- R9: With code 5, the counter rises by one on each clock edge at which `cnt_en_i` is 1 and the synchronized trigger is at its active level. It holds its value, without clearing, while the trigger is inactive.
- R10: With code 6, an active trigger edge sets `run_o` without changing the count. The counter then rises every cycle while `run_o` or `cnt_en_i` is 1. `run_o` returns to 0 once a code other than 6 or 8 is applied.
- R11: With code 7, the counter rises by one per active trigger edge while `cnt_en_i` is 1, and at no other time.
- R12: With code 8, an active trigger edge loads 0, pulses `upd_o` and sets `run_o`, and counting then continues from 0.
- R13: With `trig_pol_i` at 0, the active edge is rising and the active level is high. With `trig_pol_i` at 1, both are inverted: the active edge is falling and the active level is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode_i | input | 4 | Slave-mode code (0 to 8 used, 9 to 15 act as 0) |
| cnt_en_i | input | 1 | Counter-enable bit |
| trig_i | input | 1 | Selected trigger input, asynchronous |
| trig_pol_i | input | 1 | Trigger polarity: 1 inverts the trigger |
| ch1_i | input | 1 | Filtered channel-1 input, asynchronous |
| ch2_i | input | 1 | Filtered channel-2 input, asynchronous |
| arr_i | input | 16 | Auto-reload limit |
| cnt_o | output | 16 | Counter value |
| dir_o | output | 1 | 1 when the last encoder step was downward |
| upd_o | output | 1 | One-cycle update event |
| run_o | output | 1 | Start latch set by trigger-driven starts |

## Verification
The properties take for granted three things. `arr_i` is held steady while the counter runs. `trig_pol_i` changes only while a code that ignores trigger edges is applied, because an inversion flip shows up as an edge. The two channels never change in the same synchronized cycle. The stimulus therefore changes the limit and the polarity only with counting idle under code 0. It moves the encoder inputs one channel at a time, and each level is held four clocks, so every change passes the synchronizer alone. Random walks with a fixed seed mix up and down steps across the wrap points, and directed sequences cover the trigger-driven modes.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [3:0] {
    SM_OFF       = 4'd0,
    SM_ENC_A     = 4'd1,
    SM_ENC_B     = 4'd2,
    SM_ENC_AB    = 4'd3,
    SM_RESET     = 4'd4,
    SM_GATED     = 4'd5,
    SM_TRIGGER   = 4'd6,
    SM_EXTCLK    = 4'd7,
    SM_RST_START = 4'd8
  } slave_mode_e;

  typedef struct packed {
    logic valid;
    logic up;
  } enc_step_t;

  // Codes above the last defined mode fall back to free running.
  function automatic slave_mode_e decode_mode(input logic [3:0] code);
    if (code > 4'd8) return SM_OFF;
    return slave_mode_e'(code);
  endfunction

  function automatic logic is_encoder(input slave_mode_e m);
    return (m == SM_ENC_A) || (m == SM_ENC_B) || (m == SM_ENC_AB);
  endfunction

  // One quadrature step from the old and new levels of both channels.
  // A change on a alone counts up when new a differs from b;
  // a change on b alone counts up when new b equals a.
  function automatic enc_step_t enc_step(input slave_mode_e m,
                                         input logic a_now, input logic a_old,
                                         input logic b_now, input logic b_old);
    enc_step_t r;
    logic a_chg;
    logic b_chg;
    a_chg = a_now ^ a_old;
    b_chg = b_now ^ b_old;
    r = '0;
    if (a_chg && !b_chg && (m == SM_ENC_A || m == SM_ENC_AB)) begin
      r.valid = 1'b1;
      r.up    = a_now ^ b_now;
    end else if (b_chg && !a_chg && (m == SM_ENC_B || m == SM_ENC_AB)) begin
      r.valid = 1'b1;
      r.up    = ~(b_now ^ a_now);
    end
    return r;
  endfunction

endpackage

// File: rtl/tsc_sync_edge.sv
module tsc_sync_edge #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  input  logic [W-1:0] invert_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] prev_o
);

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic              prev_q;
      logic              lvl;

      assign lvl = chain_q[STAGES-1] ^ invert_i[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
          prev_q  <= 1'b0;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], async_i[i]};
          prev_q  <= lvl;
        end
      end

      assign level_o[i] = lvl;
      assign prev_o[i]  = prev_q;
    end
  endgenerate

endmodule

// File: rtl/tsc_mode_ctrl.sv
module tsc_mode_ctrl
  import tsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  slave_mode_e mode_i,
  input  logic        cnt_en_i,
  input  logic        trig_lvl_i,
  input  logic        trig_old_i,
  input  logic [1:0]  ch_lvl_i,
  input  logic [1:0]  ch_old_i,
  output logic        step_o,
  output logic        step_up_o,
  output logic        reinit_o,
  output logic        trig_edge_o,
  output logic        run_o
);

  logic      run_q;
  logic      trig_edge;
  logic      en_eff;
  logic      start_mode;
  enc_step_t enc;

  assign trig_edge  = trig_lvl_i & ~trig_old_i;
  assign start_mode = (mode_i == SM_TRIGGER) || (mode_i == SM_RST_START);
  assign en_eff     = cnt_en_i | run_q;
  assign enc        = enc_step(mode_i, ch_lvl_i[0], ch_old_i[0], ch_lvl_i[1], ch_old_i[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= 1'b0;
    else if (!start_mode) run_q <= 1'b0;
    else if (trig_edge)   run_q <= 1'b1;
  end

  always_comb begin
    step_o    = 1'b0;
    step_up_o = 1'b1;
    reinit_o  = 1'b0;
    unique case (mode_i)
      SM_ENC_A, SM_ENC_B, SM_ENC_AB: begin
        step_o    = cnt_en_i & enc.valid;
        step_up_o = enc.up;
      end
      SM_RESET: begin
        reinit_o = trig_edge;
        step_o   = cnt_en_i;
      end
      SM_GATED:     step_o = cnt_en_i & trig_lvl_i;
      SM_TRIGGER:   step_o = en_eff;
      SM_EXTCLK:    step_o = cnt_en_i & trig_edge;
      SM_RST_START: begin
        reinit_o = trig_edge;
        step_o   = en_eff;
      end
      default:      step_o = cnt_en_i;
    endcase
  end

  assign trig_edge_o = trig_edge;
  assign run_o       = run_q;

endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             reinit_i,
  input  logic             track_dir_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             dir_o
);

  // Returns {wrapped, next value}.
  function automatic logic [CNT_W:0] advance(input logic [CNT_W-1:0] cur,
                                             input logic [CNT_W-1:0] lim,
                                             input logic up);
    if (up) begin
      if (cur >= lim) return {1'b1, {CNT_W{1'b0}}};
      return {1'b0, cur + 1'b1};
    end
    if (cur == '0) return {1'b1, lim};
    return {1'b0, cur - 1'b1};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             upd_q;
  logic             dir_q;
  logic [CNT_W:0]   nxt;

  assign nxt = advance(cnt_q, arr_i, up_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else if (reinit_i) begin
      cnt_q <= '0;
      upd_q <= 1'b1;
    end else if (step_i) begin
      cnt_q <= nxt[CNT_W-1:0];
      upd_q <= nxt[CNT_W];
    end else begin
      upd_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dir_q <= 1'b0;
    else if (!track_dir_i) dir_q <= 1'b0;
    else if (step_i)       dir_q <= ~up_i;
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;
  assign dir_o = dir_q;

endmodule

// File: rtl/tmr_slave_counter.sv
module tmr_slave_counter
  import tsc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       slave_mode_i,
  input  logic             cnt_en_i,
  input  logic             trig_i,
  input  logic             trig_pol_i,
  input  logic             ch1_i,
  input  logic             ch2_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             upd_o,
  output logic             run_o
);

  localparam int N_IN = 3;

  slave_mode_e     mode;
  logic [N_IN-1:0] lvl;
  logic [N_IN-1:0] old;
  logic            step_w;
  logic            step_up_w;
  logic            reinit_w;
  logic            trig_lvl_w;
  logic            trig_edge_w;

  assign mode       = decode_mode(slave_mode_i);
  assign trig_lvl_w = lvl[0];

  tsc_sync_edge #(.W(N_IN), .STAGES(SYNC_STGS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_i  ({ch2_i, ch1_i, trig_i}),
    .invert_i ({2'b00, trig_pol_i}),
    .level_o  (lvl),
    .prev_o   (old)
  );

  tsc_mode_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .cnt_en_i    (cnt_en_i),
    .trig_lvl_i  (lvl[0]),
    .trig_old_i  (old[0]),
    .ch_lvl_i    (lvl[2:1]),
    .ch_old_i    (old[2:1]),
    .step_o      (step_w),
    .step_up_o   (step_up_w),
    .reinit_o    (reinit_w),
    .trig_edge_o (trig_edge_w),
    .run_o       (run_o)
  );

  tsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_w),
    .up_i        (step_up_w),
    .reinit_i    (reinit_w),
    .track_dir_i (is_encoder(mode)),
    .arr_i       (arr_i),
    .cnt_o       (cnt_o),
    .upd_o       (upd_o),
    .dir_o       (dir_o)
  );

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       slave_mode_i,
  input logic [CNT_W-1:0] arr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             upd_o,
  input logic             dir_o,
  input logic             step_w,
  input logic             step_up_w,
  input logic             reinit_w,
  input logic             trig_lvl_w,
  input logic             trig_edge_w
);

  logic enc_code;
  assign enc_code = (slave_mode_i == 4'd1) || (slave_mode_i == 4'd2) || (slave_mode_i == 4'd3);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_w && !reinit_w) |=> ($stable(cnt_o) && !upd_o)); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && step_up_w && !reinit_w && cnt_o < arr_i) |=> (cnt_o == $past(cnt_o) + 1'b1 && !upd_o)); // R3

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && step_up_w && !reinit_w && cnt_o == arr_i) |=> (cnt_o == '0 && upd_o)); // R3

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && !step_up_w && !reinit_w && cnt_o == '0) |=> (cnt_o == $past(arr_i) && upd_o)); // R7

  AST_DIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_code |=> !dir_o); // R7

  AST_REINIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_w |=> (cnt_o == '0 && upd_o)); // R8

  AST_REINIT_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode_i != 4'd4 && slave_mode_i != 4'd8) |-> !reinit_w); // R8

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode_i == 4'd5 && !trig_lvl_w) |-> !step_w); // R9

  AST_EXT_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode_i == 4'd7 && step_w) |-> trig_edge_w); // R11

endmodule

bind tmr_slave_counter tsc_checker #(.CNT_W(CNT_W)) u_tsc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .slave_mode_i (slave_mode_i),
  .arr_i        (arr_i),
  .cnt_o        (cnt_o),
  .upd_o        (upd_o),
  .dir_o        (dir_o),
  .step_w       (step_w),
  .step_up_w    (step_up_w),
  .reinit_w     (reinit_w),
  .trig_lvl_w   (trig_lvl_w),
  .trig_edge_w  (trig_edge_w)
);

// File: tb/tmr_slave_counter_bench.sv
`timescale 1ns/1ps
module tmr_slave_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  slave_mode_i;
  logic        cnt_en_i, trig_i, trig_pol_i, ch1_i, ch2_i;
  logic [15:0] arr_i;
  logic [15:0] cnt_o;
  logic        dir_o, upd_o, run_o;

  int checks = 0;
  int errors = 0;
  int upd_seen = 0;
  bit done = 0;

  int exp_cnt;
  int exp_upd;
  int exp_dir;
  int lim;

  always #4 clk = ~clk;

  tmr_slave_counter u_tmr_slave_counter (
    .clk(clk), .rst_n(rst_n), .slave_mode_i(slave_mode_i), .cnt_en_i(cnt_en_i),
    .trig_i(trig_i), .trig_pol_i(trig_pol_i), .ch1_i(ch1_i), .ch2_i(ch2_i),
    .arr_i(arr_i), .cnt_o(cnt_o), .dir_o(dir_o), .upd_o(upd_o), .run_o(run_o)
  );

  always @(posedge clk) if (rst_n && upd_o) upd_seen++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // n upward steps from a value not above the limit: position on a ring of lim+1.
  task automatic model_up(input int n);
    int total;
    total   = exp_cnt + n;
    exp_upd = exp_upd + total / (lim + 1);
    exp_cnt = total % (lim + 1);
  endtask

  task automatic check_state(input string req);
    chk(req, "count", int'(cnt_o), exp_cnt);
    chk(req, "updates", upd_seen, exp_upd);
  endtask

  task automatic run_code(input int n, input logic [3:0] code);
    slave_mode_i = code;
    cnt_en_i = 1'b1;
    cyc(n);
    cnt_en_i = 1'b0;
    cyc(1);
    model_up(n);
  endtask

  task automatic pulse_trig(input logic active);
    trig_i = active;
    cyc(3);
    trig_i = ~active;
    cyc(3);
  endtask

  // Clear through the reset code with counting idle (rising active edge).
  task automatic clear_count();
    slave_mode_i = 4'd4;
    cnt_en_i = 1'b0;
    pulse_trig(1'b1);
    exp_cnt = 0;
    exp_upd++;
  endtask

  // Quadrature phase: 00 ->0, 10 ->1, 11 ->2, 01 ->3 for (ch1,ch2).
  function automatic int phase(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic enc_move(input int which, input int code, input string req);
    int  p_old, p_new;
    bit  counts;
    p_old = phase(ch1_i, ch2_i);
    if (which == 0) ch1_i = ~ch1_i; else ch2_i = ~ch2_i;
    p_new = phase(ch1_i, ch2_i);
    counts = (code == 3) || (code == 1 && which == 0) || (code == 2 && which == 1);
    cyc(4);
    if (counts) begin
      if (((p_new - p_old + 4) % 4) == 1) begin
        exp_dir = 0;
        if (exp_cnt == lim) begin exp_cnt = 0; exp_upd++; end else exp_cnt++;
      end else begin
        exp_dir = 1;
        if (exp_cnt == 0) begin exp_cnt = lim; exp_upd++; end else exp_cnt--;
      end
    end
    check_state(req);
    chk(req, "direction", int'(dir_o), exp_dir);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; slave_mode_i = 4'd0; cnt_en_i = 1'b0; trig_i = 1'b0;
    trig_pol_i = 1'b0; ch1_i = 1'b0; ch2_i = 1'b0;
    lim = 10 + int'($urandom % 40);
    arr_i = 16'(lim);
    exp_cnt = 0; exp_upd = 0; exp_dir = 0;
    cyc(3);
    chk("R1", "count in reset", int'(cnt_o), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", "count after reset", int'(cnt_o), 0);
    chk("R1", "update after reset", int'(upd_o), 0);
    chk("R1", "dir after reset", int'(dir_o), 0);
    chk("R1", "run after reset", int'(run_o), 0);

    // R2 / R3: free running, wraps included, channel and trigger noise ignored.
    for (int i = 0; i < 6; i++) begin
      logic [3:0] code;
      code = (i % 2 == 0) ? 4'd0 : 4'(9 + ($urandom % 7));
      run_code(5 + int'($urandom % 90), code);
      check_state("R2/R3");
    end
    slave_mode_i = 4'd0;
    ch1_i = 1'b1; cyc(4); ch2_i = 1'b1; cyc(4); ch1_i = 1'b0; ch2_i = 1'b0; cyc(4);
    check_state("R2 idle with channel activity");

    // Encoder walks in every encoder code.
    for (int code = 1; code <= 3; code++) begin
      slave_mode_i = 4'(code);
      cnt_en_i = 1'b1;
      for (int k = 0; k < 40; k++) begin
        int which;
        which = int'($urandom % 2);
        enc_move(which, code, code == 1 ? "R4" : (code == 2 ? "R5" : "R6"));
      end
      cnt_en_i = 1'b0;
    end
    slave_mode_i = 4'd0; cyc(2);
    exp_dir = 0;
    chk("R7", "dir after leaving encoder", int'(dir_o), 0);

    // R7 directed: down wrap from zero.
    clear_count();
    cyc(2);
    ch1_i = 1'b0; ch2_i = 1'b0; cyc(4);
    check_state("R8 clear");
    slave_mode_i = 4'd3; cnt_en_i = 1'b1;
    enc_move(1, 3, "R7");
    chk("R7", "down wrap value", int'(cnt_o), lim);
    enc_move(1, 3, "R7 back up");
    cnt_en_i = 1'b0;

    // R8: reset code counts like code 0 without trigger.
    run_code(7, 4'd4);
    check_state("R8 counting");
    clear_count();
    check_state("R8 trigger clear");

    // R9: gated.
    slave_mode_i = 4'd5; cnt_en_i = 1'b1;
    cyc(6);
    check_state("R9 gate closed");
    for (int i = 0; i < 3; i++) begin
      int n;
      n = 3 + int'($urandom % 20);
      trig_i = 1'b1; cyc(n); trig_i = 1'b0; cyc(5);
      model_up(n);
      check_state("R9 gated run");
    end
    cnt_en_i = 1'b0;

    // R11: external clock.
    slave_mode_i = 4'd7; cnt_en_i = 1'b1;
    for (int i = 0; i < 5; i++) pulse_trig(1'b1);
    model_up(5);
    check_state("R11 edges");
    cyc(6);
    check_state("R11 no edge no step");
    cnt_en_i = 1'b0;

    // R13: inverted polarity, set while idle under code 0.
    slave_mode_i = 4'd0; trig_i = 1'b1; cyc(2); trig_pol_i = 1'b1; cyc(4);
    slave_mode_i = 4'd7; cnt_en_i = 1'b1;
    for (int i = 0; i < 4; i++) pulse_trig(1'b0);
    model_up(4);
    check_state("R13 falling edges");
    slave_mode_i = 4'd5;
    trig_i = 1'b0; cyc(9); trig_i = 1'b1; cyc(5);
    model_up(9);
    check_state("R13 low-level gate");
    cnt_en_i = 1'b0; slave_mode_i = 4'd0;
    trig_i = 1'b0; cyc(2); trig_pol_i = 1'b0; cyc(4);
    check_state("R13 restore");

    // R10: trigger start, count not cleared.
    lim = 1000; arr_i = 16'(lim);
    run_code(5, 4'd0);
    slave_mode_i = 4'd6; cyc(3);
    chk("R10", "run before trigger", int'(run_o), 0);
    check_state("R10 idle before trigger");
    trig_i = 1'b1; cyc(1); trig_i = 1'b0; cyc(8);
    chk("R10", "run after trigger", int'(run_o), 1);
    chk("R10", "count kept and rising", int'(cnt_o > 16'(exp_cnt)), 1);
    chk("R10", "no update", upd_seen, exp_upd);
    slave_mode_i = 4'd0; cyc(2);
    chk("R10", "run cleared", int'(run_o), 0);
    exp_cnt = int'(cnt_o);
    cyc(3);
    check_state("R10 stopped");

    // R12: combined clear and start.
    slave_mode_i = 4'd8;
    trig_i = 1'b1; cyc(4);
    exp_upd++;
    chk("R12", "run set", int'(run_o), 1);
    chk("R12", "restart near zero", int'(cnt_o <= 16'd2), 1);
    chk("R12", "update", upd_seen, exp_upd);
    trig_i = 1'b0;
    slave_mode_i = 4'd0; cyc(2);
    exp_cnt = int'(cnt_o);
    cyc(3);
    check_state("R12 stopped");

    done = 1;
    summary();
    $finish;
  end

endmodule